// File: doc/BRIEF.md
# RV32I to Wide-Instruction Translator

This block converts one 32-bit RV32I instruction word, together with the program counter it was fetched from, into one 64-bit instruction of a reduced virtual-machine instruction set. Every output word has the same shape. It holds an opcode byte, a destination register, two source registers and a 32-bit immediate. The block decodes the RISC-V formats and extracts the sign-extended immediates. It then folds several RISC-V forms into one output operation. Both upper-immediate loads become an add from x0. The pc-relative upper immediate is resolved at translation time. Both jumps become a single jump operation.

A word presented with `in_valid` high is translated in the same cycle and registered. The result appears on the following cycle, with `out_valid` high. The subset covers loads, stores, branches, the register and immediate ALU forms, fence, ecall, ebreak and the explicit unimp word. A word outside that subset, including the all-zero word, is translated into a rejecting halt, and `out_illegal` is raised for that one output cycle. Fetch, program loading, execution and the register file are outside this block.

Top module: `rvx_wide_xlate`

## Requirements
- R1: The output word is laid out as opcode [63:56], destination [55:48], first source [47:40], second source [39:32] and immediate [31:0]. Each 5-bit register index is zero-extended to 8 bits, so bits [55:53], [47:45] and [39:37] are always 0.
- R2: Reset clears `out_valid`, `out_illegal` and `out_insn` to 0. An input accepted with `in_valid` high at a rising edge appears one cycle later with `out_valid` high. A cycle without `in_valid` gives `out_valid` 0 and `out_illegal` 0 in the next cycle.
- R3: lui rd,imm (opcode field 0x37) gives add (0x40) with rd, x0, x0 and the immediate insn[31:12] shifted left by 12.
- R4: auipc rd,imm (opcode field 0x17) gives add (0x40) with rd, x0, x0 and the immediate (pc + (insn[31:12] << 12)) mod 2^32.
- R5: A register-register ALU word (opcode field 0x33) keeps rd, rs1 and rs2 and sets the immediate to 0. The funct7 field may be 0x00 for any funct3, or 0x20 for funct3 0 or 5 only. The output opcodes are add 0x40, sub 0x41, slt 0x42, sltu 0x43, sll 0x44, srl 0x45, sra 0x46, or 0x47, and 0x48 and xor 0x49.
- R6: A register-immediate ALU word (opcode field 0x13) keeps rd and rs1, sets rs2 to 0, and uses the R5 opcodes. The immediate is insn[31:20] sign-extended. The shifts are the exception: slli needs funct7 0x00, srli needs funct7 0x00 and srai needs funct7 0x20, and for these the immediate is insn[24:20] zero-extended.
- R7: jal (opcode field 0x6F) gives jump 0x10 with rd, x0, x0 and the sign-extended J immediate. jalr (opcode field 0x67, funct3 0 only) gives jump 0x10 with rd, rs1, x0 and the sign-extended I immediate.
- R8: A conditional branch (opcode field 0x63) gives 0x11 to 0x16 for funct3 0, 1, 4, 5, 6 and 7 (beq, bne, blt, bge, bltu, bgeu). The output has destination 0, keeps rs1 and rs2, and carries the sign-extended B immediate. funct3 2 and 3 are unsupported.
- R9: A load (opcode field 0x03) gives 0x20 to 0x24 for funct3 0, 1, 2, 4 and 5, with rd, rs1, x0 and the I immediate. A store (opcode field 0x23) gives 0x28 to 0x2A for funct3 0 to 2, with destination 0, rs1, rs2 and the S immediate.
- R10: fence (opcode field 0x0F, funct3 0) and the ebreak word 0x00100073 both give nop 0x01 with every other field 0. The ecall word 0x00000073 gives 0x03 with every other field 0.
- R11: The unimp word 0xC0001073 gives halt 0x02 with all registers 0 and immediate 1, and `out_illegal` stays 0.
- R12: Any other encoding gives halt 0x02 with all registers 0 and immediate 1, and `out_illegal` is 1 in that output cycle only. This includes an unknown opcode field, low bits other than 11, a bad funct3 or funct7, any other system word, and the all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_insn | input | 32 | RV32I instruction word |
| in_pc | input | 32 | Address of the instruction word |
| out_valid | output | 1 | Translated word is present |
| out_insn | output | 64 | Translated wide instruction |
| out_illegal | output | 1 | Input encoding was unsupported |

## Verification
Two events can land in the same cycle. The illegal flag from one word must clear while the legal translation of the next word is presented. This is provoked by feeding all 128 opcode fields back to back, with random upper bits, so that unsupported and supported words alternate with no idle cycle between them. It is judged by comparing the flag and the whole 64-bit word against an arithmetic model in every output cycle. A second pairing is the pc addition and the upper-immediate extraction meeting in one auipc. This is pushed to the 2^32 wrap with a pc near the top of the address space.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned VREG_W  = 8;
  localparam int unsigned VOP_W   = 8;
  localparam int unsigned VINSN_W = VOP_W + 3 * VREG_W + XLEN;

  // immediate shaping selector
  typedef enum logic [2:0] {
    IMM_ZERO, IMM_I, IMM_S, IMM_B, IMM_U, IMM_J, IMM_SHAMT, IMM_ONE
  } imm_fmt_e;

  // RV32I major opcode fields
  localparam logic [6:0] RV_LOAD   = 7'h03;
  localparam logic [6:0] RV_FENCE  = 7'h0F;
  localparam logic [6:0] RV_OPIMM  = 7'h13;
  localparam logic [6:0] RV_AUIPC  = 7'h17;
  localparam logic [6:0] RV_STORE  = 7'h23;
  localparam logic [6:0] RV_OP     = 7'h33;
  localparam logic [6:0] RV_LUI    = 7'h37;
  localparam logic [6:0] RV_BRANCH = 7'h63;
  localparam logic [6:0] RV_JALR   = 7'h67;
  localparam logic [6:0] RV_JAL    = 7'h6F;
  localparam logic [6:0] RV_SYSTEM = 7'h73;

  localparam logic [XLEN-1:0] W_ECALL  = 32'h0000_0073;
  localparam logic [XLEN-1:0] W_EBREAK = 32'h0010_0073;
  localparam logic [XLEN-1:0] W_UNIMP  = 32'hC000_1073;

  // reduced-set opcodes
  localparam logic [VOP_W-1:0] VM_NOP   = 8'h01;
  localparam logic [VOP_W-1:0] VM_HALT  = 8'h02;
  localparam logic [VOP_W-1:0] VM_ECALL = 8'h03;
  localparam logic [VOP_W-1:0] VM_JUMP  = 8'h10;
  localparam logic [VOP_W-1:0] VM_BR0   = 8'h11;
  localparam logic [VOP_W-1:0] VM_BR4   = 8'h13;
  localparam logic [VOP_W-1:0] VM_LD0   = 8'h20;
  localparam logic [VOP_W-1:0] VM_LD4   = 8'h23;
  localparam logic [VOP_W-1:0] VM_ST0   = 8'h28;
  localparam logic [VOP_W-1:0] VM_ADD   = 8'h40;
  localparam logic [VOP_W-1:0] VM_SUB   = 8'h41;
  localparam logic [VOP_W-1:0] VM_SLT   = 8'h42;
  localparam logic [VOP_W-1:0] VM_SLTU  = 8'h43;
  localparam logic [VOP_W-1:0] VM_SLL   = 8'h44;
  localparam logic [VOP_W-1:0] VM_SRL   = 8'h45;
  localparam logic [VOP_W-1:0] VM_SRA   = 8'h46;
  localparam logic [VOP_W-1:0] VM_OR    = 8'h47;
  localparam logic [VOP_W-1:0] VM_AND   = 8'h48;
  localparam logic [VOP_W-1:0] VM_XOR   = 8'h49;

  function automatic logic [VOP_W-1:0] alu_code(input logic [2:0] f3, input logic alt);
    logic [VOP_W-1:0] r;
    case (f3)
      3'd0:    r = alt ? VM_SUB : VM_ADD;
      3'd1:    r = VM_SLL;
      3'd2:    r = VM_SLT;
      3'd3:    r = VM_SLTU;
      3'd4:    r = VM_XOR;
      3'd5:    r = alt ? VM_SRA : VM_SRL;
      3'd6:    r = VM_OR;
      default: r = VM_AND;
    endcase
    return r;
  endfunction

  // funct3 0,1 -> 0x11,0x12 ; 4..7 -> 0x13..0x16
  function automatic logic [VOP_W-1:0] branch_code(input logic [2:0] f3);
    return f3[2] ? VM_BR4 + VOP_W'(f3[1:0]) : VM_BR0 + VOP_W'(f3[0]);
  endfunction

  // funct3 0,1,2 -> 0x20..0x22 ; 4,5 -> 0x23,0x24
  function automatic logic [VOP_W-1:0] load_code(input logic [2:0] f3);
    return f3[2] ? VM_LD4 + VOP_W'(f3[0]) : VM_LD0 + VOP_W'(f3[1:0]);
  endfunction

  function automatic logic [XLEN-1:0] imm_i(input logic [XLEN-1:7] w);
    return {{(XLEN-12){w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s(input logic [XLEN-1:7] w);
    return {{(XLEN-12){w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_b(input logic [XLEN-1:7] w);
    return {{(XLEN-13){w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_u(input logic [XLEN-1:7] w);
    return {w[31:12], 12'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_j(input logic [XLEN-1:7] w);
    return {{(XLEN-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
  import rvx_pkg::*;
(
  input  logic [XLEN-1:0]  insn,
  output logic [VOP_W-1:0] op,
  output imm_fmt_e         fmt,
  output logic             add_pc,
  output logic             keep_rd,
  output logic             keep_rs1,
  output logic             keep_rs2,
  output logic             bad,
  output logic             is_upper,
  output logic             is_jump,
  output logic             is_rr
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];

  always_comb begin
    op       = VM_HALT;
    fmt      = IMM_ONE;
    add_pc   = 1'b0;
    keep_rd  = 1'b0;
    keep_rs1 = 1'b0;
    keep_rs2 = 1'b0;
    bad      = 1'b1;
    is_upper = 1'b0;
    is_jump  = 1'b0;
    is_rr    = 1'b0;
    case (opc)
      RV_LUI, RV_AUIPC: begin
        op       = VM_ADD;
        fmt      = IMM_U;
        add_pc   = (opc == RV_AUIPC);
        keep_rd  = 1'b1;
        bad      = 1'b0;
        is_upper = 1'b1;
      end
      RV_JAL: begin
        op      = VM_JUMP;
        fmt     = IMM_J;
        keep_rd = 1'b1;
        bad     = 1'b0;
        is_jump = 1'b1;
      end
      RV_JALR: begin
        if (f3 == 3'd0) begin
          op       = VM_JUMP;
          fmt      = IMM_I;
          keep_rd  = 1'b1;
          keep_rs1 = 1'b1;
          bad      = 1'b0;
          is_jump  = 1'b1;
        end
      end
      RV_BRANCH: begin
        if (f3[2:1] != 2'b01) begin
          op       = branch_code(f3);
          fmt      = IMM_B;
          keep_rs1 = 1'b1;
          keep_rs2 = 1'b1;
          bad      = 1'b0;
        end
      end
      RV_LOAD: begin
        if (f3[2] ? !f3[1] : (f3 != 3'd3)) begin
          op       = load_code(f3);
          fmt      = IMM_I;
          keep_rd  = 1'b1;
          keep_rs1 = 1'b1;
          bad      = 1'b0;
        end
      end
      RV_STORE: begin
        if (f3 < 3'd3) begin
          op       = VM_ST0 + VOP_W'(f3);
          fmt      = IMM_S;
          keep_rs1 = 1'b1;
          keep_rs2 = 1'b1;
          bad      = 1'b0;
        end
      end
      RV_OPIMM: begin
        keep_rd  = 1'b1;
        keep_rs1 = 1'b1;
        if (f3 == 3'd1) begin
          op  = VM_SLL;
          fmt = IMM_SHAMT;
          bad = (f7 != 7'h00);
        end else if (f3 == 3'd5) begin
          op  = f7[5] ? VM_SRA : VM_SRL;
          fmt = IMM_SHAMT;
          bad = (f7 != 7'h00) && (f7 != 7'h20);
        end else begin
          op  = alu_code(f3, 1'b0);
          fmt = IMM_I;
          bad = 1'b0;
        end
        if (bad) begin
          op       = VM_HALT;
          fmt      = IMM_ONE;
          keep_rd  = 1'b0;
          keep_rs1 = 1'b0;
        end
      end
      RV_OP: begin
        if ((f7 == 7'h00) || ((f7 == 7'h20) && (f3 == 3'd0 || f3 == 3'd5))) begin
          op       = alu_code(f3, f7[5]);
          fmt      = IMM_ZERO;
          keep_rd  = 1'b1;
          keep_rs1 = 1'b1;
          keep_rs2 = 1'b1;
          bad      = 1'b0;
          is_rr    = 1'b1;
        end
      end
      RV_FENCE: begin
        if (f3 == 3'd0) begin
          op  = VM_NOP;
          fmt = IMM_ZERO;
          bad = 1'b0;
        end
      end
      RV_SYSTEM: begin
        if (insn == W_ECALL) begin
          op  = VM_ECALL;
          fmt = IMM_ZERO;
          bad = 1'b0;
        end else if (insn == W_EBREAK) begin
          op  = VM_NOP;
          fmt = IMM_ZERO;
          bad = 1'b0;
        end else if (insn == W_UNIMP) begin
          bad = 1'b0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rvx_imm.sv
module rvx_imm
  import rvx_pkg::*;
(
  input  logic [XLEN-1:7] insn_hi,
  input  logic [XLEN-1:0] pc,
  input  imm_fmt_e        fmt,
  input  logic            add_pc,
  output logic [XLEN-1:0] imm
);

  logic [XLEN-1:0] base;

  always_comb begin
    case (fmt)
      IMM_I:     base = imm_i(insn_hi);
      IMM_S:     base = imm_s(insn_hi);
      IMM_B:     base = imm_b(insn_hi);
      IMM_U:     base = imm_u(insn_hi);
      IMM_J:     base = imm_j(insn_hi);
      IMM_SHAMT: base = XLEN'(insn_hi[24:20]);
      IMM_ONE:   base = XLEN'(1);
      default:   base = '0;
    endcase
  end

  // pc-relative fold wraps modulo 2^XLEN
  assign imm = add_pc ? base + pc : base;

endmodule

// File: rtl/rvx_wide_xlate.sv
module rvx_wide_xlate
  import rvx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [XLEN-1:0]     in_insn,
  input  logic [XLEN-1:0]     in_pc,
  output logic                out_valid,
  output logic [VINSN_W-1:0]  out_insn,
  output logic                out_illegal
);

  localparam int unsigned OP_LSB  = XLEN + 3 * VREG_W;
  localparam int unsigned RD_LSB  = XLEN + 2 * VREG_W;
  localparam int unsigned RS1_LSB = XLEN + VREG_W;
  localparam int unsigned RS2_LSB = XLEN;
  localparam int unsigned PAD_W   = VREG_W - RIDX_W;

  logic [VOP_W-1:0]   dec_op;
  imm_fmt_e           dec_fmt;
  logic               dec_add_pc;
  logic               dec_keep_rd;
  logic               dec_keep_rs1;
  logic               dec_keep_rs2;
  logic               dec_bad;
  logic               dec_is_upper;
  logic               dec_is_jump;
  logic               dec_is_rr;
  logic [XLEN-1:0]    xl_imm;
  logic [VREG_W-1:0]  f_rd;
  logic [VREG_W-1:0]  f_rs1;
  logic [VREG_W-1:0]  f_rs2;
  logic [VINSN_W-1:0] next_word;

  rvx_decode u_decode (
    .insn     (in_insn),
    .op       (dec_op),
    .fmt      (dec_fmt),
    .add_pc   (dec_add_pc),
    .keep_rd  (dec_keep_rd),
    .keep_rs1 (dec_keep_rs1),
    .keep_rs2 (dec_keep_rs2),
    .bad      (dec_bad),
    .is_upper (dec_is_upper),
    .is_jump  (dec_is_jump),
    .is_rr    (dec_is_rr)
  );

  rvx_imm u_imm (
    .insn_hi (in_insn[XLEN-1:7]),
    .pc      (in_pc),
    .fmt     (dec_fmt),
    .add_pc  (dec_add_pc),
    .imm     (xl_imm)
  );

  assign f_rd  = dec_keep_rd  ? {{PAD_W{1'b0}}, in_insn[11:7]}  : '0;
  assign f_rs1 = dec_keep_rs1 ? {{PAD_W{1'b0}}, in_insn[19:15]} : '0;
  assign f_rs2 = dec_keep_rs2 ? {{PAD_W{1'b0}}, in_insn[24:20]} : '0;

  assign next_word = {dec_op, f_rd, f_rs1, f_rs2, xl_imm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_insn    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && dec_bad;
      if (in_valid) out_insn <= next_word;
    end
  end

  // R2: accepted input shows up one cycle later
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: idle cycle leaves no output and no flag
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal));

  // R12: flag only ever accompanies a rejecting halt
  assert_illegal_is_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_insn[OP_LSB +: VOP_W] == VM_HALT
                     && out_insn[RS2_LSB +: 3*VREG_W] == '0
                     && out_insn[XLEN-1:0] == XLEN'(1)));

  // R1: register fields are zero-extended
  assert_reg_zext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_insn[RD_LSB + RIDX_W +: PAD_W] == '0
                   && out_insn[RS1_LSB + RIDX_W +: PAD_W] == '0
                   && out_insn[RS2_LSB + RIDX_W +: PAD_W] == '0));

  // R3: upper-immediate forms become add from x0
  assert_upper_from_x0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_is_upper) |=> (out_insn[OP_LSB +: VOP_W] == VM_ADD
                                    && out_insn[RS2_LSB +: 2*VREG_W] == '0));

  // R7: both jumps share one opcode and never use the second source
  assert_single_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_is_jump) |=> (out_insn[OP_LSB +: VOP_W] == VM_JUMP
                                   && out_insn[RS2_LSB +: VREG_W] == '0));

  // R5: register-register forms carry a zero immediate
  assert_rr_zero_imm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_is_rr) |=> (out_insn[XLEN-1:0] == '0 && !out_illegal));

endmodule

// File: tb/test_rvx_wide_xlate.sv
`timescale 1ns/1ps
module test_rvx_wide_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [31:0] in_pc;
  logic        out_valid;
  logic [63:0] out_insn;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit          pend_v   = 1'b0;
  logic [63:0] pend_e   = '0;
  bit          pend_ill = 1'b0;
  string       pend_tag = "R2";
  logic [31:0] seed     = 32'h1234_5679;

  always #2.5 clk = ~clk;

  rvx_wide_xlate i_rvx_wide_xlate (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_insn     (in_insn),
    .in_pc       (in_pc),
    .out_valid   (out_valid),
    .out_insn    (out_insn),
    .out_illegal (out_illegal)
  );

  function automatic logic [31:0] rnd();
    logic [31:0] s = seed;
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    seed = s;
    return s;
  endfunction

  // sign-interpret an unsigned field value of the given width
  function automatic logic [31:0] sgn(input longint v, input int bits);
    longint r = v;
    if (v >= (longint'(1) << (bits - 1))) r = v - (longint'(1) << bits);
    return 32'(r);
  endfunction

  function automatic void model(input logic [31:0] w, input logic [31:0] pc,
                                output logic [63:0] e, output bit ill, output string tag);
    int     opc = int'(w[6:0]);
    int     f3  = int'(w[14:12]);
    int     f7  = int'(w[31:25]);
    int     rd  = int'(w[11:7]);
    int     r1  = int'(w[19:15]);
    int     r2  = int'(w[24:20]);
    longint vi  = longint'(w[31:20]);
    longint vs  = longint'(w[31:25]) * 32 + longint'(w[11:7]);
    longint vb  = longint'(w[31]) * 4096 + longint'(w[7]) * 2048
                + longint'(w[30:25]) * 32 + longint'(w[11:8]) * 2;
    longint vj  = longint'(w[31]) * 1048576 + longint'(w[19:12]) * 4096
                + longint'(w[20]) * 2048 + longint'(w[30:21]) * 2;
    longint vu  = longint'(w[31:12]) * 4096;
    int alu[8];
    int brt[8];
    int ldt[8];
    int op; int o_rd; int o_r1; int o_r2; logic [31:0] im;
    alu = '{'h40, 'h44, 'h42, 'h43, 'h49, 'h45, 'h47, 'h48};
    brt = '{'h11, 'h12, -1, -1, 'h13, 'h14, 'h15, 'h16};
    ldt = '{'h20, 'h21, 'h22, -1, 'h23, 'h24, -1, -1};
    op = 2; o_rd = 0; o_r1 = 0; o_r2 = 0; im = 32'd1; ill = 1'b1; tag = "R12 unsupported";
    if (opc == 'h37) begin
      op = 'h40; o_rd = rd; im = 32'(vu); ill = 0; tag = "R3 lui";
    end else if (opc == 'h17) begin
      op = 'h40; o_rd = rd; im = 32'(vu + longint'(pc)); ill = 0; tag = "R4 auipc";
    end else if (opc == 'h6F) begin
      op = 'h10; o_rd = rd; im = sgn(vj, 21); ill = 0; tag = "R7 jal";
    end else if (opc == 'h67 && f3 == 0) begin
      op = 'h10; o_rd = rd; o_r1 = r1; im = sgn(vi, 12); ill = 0; tag = "R7 jalr";
    end else if (opc == 'h63 && brt[f3] > 0) begin
      op = brt[f3]; o_r1 = r1; o_r2 = r2; im = sgn(vb, 13); ill = 0; tag = "R8 branch";
    end else if (opc == 'h03 && ldt[f3] > 0) begin
      op = ldt[f3]; o_rd = rd; o_r1 = r1; im = sgn(vi, 12); ill = 0; tag = "R9 load";
    end else if (opc == 'h23 && f3 <= 2) begin
      op = 'h28 + f3; o_r1 = r1; o_r2 = r2; im = sgn(vs, 12); ill = 0; tag = "R9 store";
    end else if (opc == 'h13) begin
      if (f3 == 1 && f7 == 0) begin
        op = 'h44; o_rd = rd; o_r1 = r1; im = 32'(r2); ill = 0; tag = "R6 slli";
      end else if (f3 == 5 && (f7 == 0 || f7 == 'h20)) begin
        op = (f7 == 0) ? 'h45 : 'h46; o_rd = rd; o_r1 = r1; im = 32'(r2); ill = 0;
        tag = "R6 shift right imm";
      end else if (f3 != 1 && f3 != 5) begin
        op = alu[f3]; o_rd = rd; o_r1 = r1; im = sgn(vi, 12); ill = 0; tag = "R6 alu imm";
      end
    end else if (opc == 'h33) begin
      if (f7 == 0) begin
        op = alu[f3]; o_rd = rd; o_r1 = r1; o_r2 = r2; im = 0; ill = 0; tag = "R5 alu reg";
      end else if (f7 == 'h20 && (f3 == 0 || f3 == 5)) begin
        op = (f3 == 0) ? 'h41 : 'h46; o_rd = rd; o_r1 = r1; o_r2 = r2; im = 0; ill = 0;
        tag = "R5 sub/sra";
      end
    end else if (opc == 'h0F && f3 == 0) begin
      op = 1; im = 0; ill = 0; tag = "R10 fence";
    end else if (w == 32'h0000_0073) begin
      op = 3; im = 0; ill = 0; tag = "R10 ecall";
    end else if (w == 32'h0010_0073) begin
      op = 1; im = 0; ill = 0; tag = "R10 ebreak";
    end else if (w == 32'hC000_1073) begin
      ill = 0; tag = "R11 unimp";
    end
    e = {8'(op), 8'(o_rd), 8'(o_r1), 8'(o_r2), im};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    check("R2 out_valid", 64'(out_valid), 64'(pend_v));
    if (pend_v) begin
      check(pend_tag, out_insn, pend_e);
      check({"R12 flag for ", pend_tag}, 64'(out_illegal), 64'(pend_ill));
    end else begin
      check("R2 flag idle", 64'(out_illegal), 64'd0);
    end
  endtask

  task automatic drive(input bit v, input logic [31:0] w, input logic [31:0] pc);
    logic [63:0] e; bit ill; string tag;
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_insn  = w;
    in_pc    = pc;
    model(w, pc, e, ill, tag);
    pend_v   = v;
    pend_e   = e;
    pend_ill = ill;
    pend_tag = tag;
  endtask

  task automatic expect_literal(input logic [31:0] w, input logic [31:0] pc,
                                input logic [63:0] lit, input string tag);
    drive(1'b1, w, pc);
    @(negedge clk);
    check(tag, out_insn, lit);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [6:0] majors [11];
    logic [6:0] f7s [4];
    majors = '{7'h03, 7'h0F, 7'h13, 7'h17, 7'h23, 7'h33, 7'h37, 7'h63, 7'h67, 7'h6F, 7'h73};
    f7s    = '{7'h00, 7'h20, 7'h01, 7'h40};
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_pc = '0;
    repeat (3) @(negedge clk);
    check("R2 reset valid", 64'(out_valid), 64'd0);
    check("R2 reset word", out_insn, 64'd0);
    check("R2 reset flag", 64'(out_illegal), 64'd0);
    rst_n = 1'b1;

    // R1 layout: and x5,x6,x7
    expect_literal(32'h0073_72B3, 32'h0, 64'h4805_0607_0000_0000, "R1 layout and");
    // R5 xor x31,x1,x2
    expect_literal(32'h0020_CFB3, 32'h0, 64'h491F_0102_0000_0000, "R5 xor");
    // R4 wrap: auipc x1,0x2 at pc 0xFFFFF000
    expect_literal(32'h0000_2097, 32'hFFFF_F000, 64'h4001_0000_0000_1000, "R4 auipc wrap");
    // R11 unimp and R12 zero word
    expect_literal(32'hC000_1073, 32'h40, 64'h0200_0000_0000_0001, "R11 unimp");
    expect_literal(32'h0000_0000, 32'h44, 64'h0200_0000_0000_0001, "R12 zero word");
    drive(1'b0, '0, '0);

    // specials back to back
    drive(1'b1, 32'h0000_0073, 32'h100);
    drive(1'b1, 32'h0010_0073, 32'h104);
    drive(1'b1, 32'h0FF0_000F, 32'h108);
    drive(1'b1, 32'h0000_1073, 32'h10C);
    drive(1'b1, 32'h0000_0013, 32'h110);
    drive(1'b1, 32'h8000_0037, 32'h114);
    drive(1'b1, 32'hFFFF_F017, 32'h0000_2000);
    drive(1'b0, '0, '0);

    // all opcode fields, random upper bits, no gaps except one per group
    for (int op7 = 0; op7 < 128; op7++) begin
      for (int k = 0; k < 12; k++) begin
        logic [31:0] r = rnd();
        if (k == 5) drive(1'b0, r, '0);
        drive(1'b1, {r[31:7], 7'(op7)}, rnd());
      end
    end

    // major opcodes across every funct3 and several funct7 values
    for (int m = 0; m < 11; m++) begin
      for (int f = 0; f < 8; f++) begin
        for (int s = 0; s < 4; s++) begin
          logic [31:0] r = rnd();
          drive(1'b1, {f7s[s], r[24:15], 3'(f), r[11:7], majors[m]}, rnd());
        end
      end
    end

    drive(1'b0, '0, '0);
    drive(1'b0, '0, '0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule